// File: doc/BRIEF.md
# Static Memory Chip-Select Timing Engine

This block runs bus cycles for one asynchronous static device (SRAM, NOR flash or a memory-mapped peripheral) on a single chip select. An internal master raises a request with an address, a write flag, write data and byte enables. The engine acknowledges the request only when it is idle. It then plays out a bus cycle made of separately programmed phases, returns read data and pulses a done flag.

The timing comes from a 32-bit configuration word written through a plain register port. Each field sets the length of one phase. The address leads and trails the chip select by the same count. The chip select leads and trails the strobe by separate counts. The strobe width is either one clock or a programmed wait count plus one. After a read, a float gap of idle clocks lets the device release the data bus. Other fields pick an 8-bit or 16-bit bus, one 16-bit device or a pair of byte-wide devices, and normal or early read timing.

Top module: `smc_cs_engine`

## Requirements
- R1: `req_ack` is high in a cycle exactly when `req_valid` is high and the engine is idle. The request is taken at that clock edge. A request raised during a bus cycle or a float gap stays unacknowledged until the engine is idle again.
- R2: Configuration bits 17:16 (value A, 0 to 3) set how many clocks the address is driven before the chip select goes low. The address is held for A further clocks after the chip select goes high. `mem_addr` equals the request address for the whole cycle.
- R3: Bits 25:24 (S) set how many clocks the active-low chip select is low before the strobe falls. Bits 29:28 (H) set how many clocks it stays low after the strobe rises. A strobe is never low while the chip select is high.
- R4: With bit 7 set, the strobe is low for bits 6:0 plus one clocks (1 to 128). With bit 7 clear, it is low for one clock and bits 6:0 are ignored.
- R5: With bit 15 set, a read skips the chip-select-to-strobe phase, so the read strobe falls in the same clock as the chip select. Writes ignore bit 15.
- R6: After a read, bits 11:8 (F) add F idle clocks, beginning with the done cycle, before a new request can be acknowledged. Writes add no gap.
- R7: Bits 14:13 equal to 2 select an 8-bit bus. Any other value selects 16 bits. On an 8-bit bus a write drives the low request byte on both byte lanes and pulses only `mem_wr_n[0]`. A read returns the low data byte zero-extended.
- R8: On a 16-bit bus with bit 12 clear, both write strobes pulse together whatever the byte enables are. With bit 12 set, `mem_wr_n[i]` pulses only when `req_be[i]` is 1.
- R9: Read data is captured at the clock edge where the read strobe rises. `done` is a one-cycle pulse in the clock after the last address-hold clock. A cycle with A=0, S=0, H=0 and a one-clock strobe puts `done` two cycles after the acknowledge cycle.
- R10: The configuration word resets to 0x0000_2000 (16-bit bus, all counts zero). It is sampled when a request is accepted, so a write to it during a cycle only affects later cycles.
- R11: During and right after reset, `mem_cs_n`, `mem_rd_n` and both `mem_wr_n` are high, and `mem_doe`, `done` and `req_ack` are low. During a write, `mem_doe` is high while the chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | New configuration word |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables |
| req_ack | output | 1 | Request accepted this cycle |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | Device address |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wr_n | output | DATA_W/8 | Active-low write strobes, one per byte lane |
| mem_dout | output | DATA_W | Data driven to the device |
| mem_doe | output | 1 | Output enable for `mem_dout` |
| mem_din | input | DATA_W | Data from the device |

## Verification
Counting the acknowledge cycle as cycle 0, the first chip-select-low clock is cycle A+1. `done` arrives at cycle 2A+S'+W+H+1, where S' is zero for early reads and W is the strobe width. The next acknowledge after a read comes F cycles after `done`. The bench samples every output on the falling clock edge. For each transaction it counts the cycles from the acknowledge cycle to these events, including chip-select-low and strobe-low clocks, and compares them with the table values derived from these formulas. Read data is checked in the `done` cycle, and write data and output enable are checked in the strobe clock.

// File: rtl/smc_pkg.sv
// Shared types for the static memory chip-select engine.
// Assumes the 32-bit configuration layout described in the brief.
package smc_pkg;

    // Bus cycle phases; the numeric order is the order they are played out.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_ASETUP = 3'd1,
        PH_CSETUP = 3'd2,
        PH_STROBE = 3'd3,
        PH_CHOLD  = 3'd4,
        PH_AHOLD  = 3'd5,
        PH_FLOAT  = 3'd6
    } phase_e;

    localparam int NUM_PHASES = 7;

    // Decoded timing fields of one configuration word.
    typedef struct packed {
        logic [1:0] cs_hold;
        logic [1:0] cs_setup;
        logic [1:0] addr_gap;
        logic       early_rd;
        logic [1:0] bus_sel;
        logic       split_dev;
        logic [3:0] float_len;
        logic       wait_en;
        logic [6:0] wait_cnt;
    } timing_t;

    localparam logic [31:0] CFG_RESET_WORD = 32'h0000_2000;

    // Pull the timing fields out of a raw configuration word.
    function automatic timing_t unpack_cfg(input logic [31:0] w);
        timing_t t;
        t.cs_hold   = w[29:28];
        t.cs_setup  = w[25:24];
        t.addr_gap  = w[17:16];
        t.early_rd  = w[15];
        t.bus_sel   = w[14:13];
        t.split_dev = w[12];
        t.float_len = w[11:8];
        t.wait_en   = w[7];
        t.wait_cnt  = w[6:0];
        return t;
    endfunction

endpackage

// File: rtl/smc_cfg_reg.sv
// Configuration holding register.
// Stores the decoded timing fields; reserved bits of the word are dropped.
// Assumes writes may arrive at any time; the engine samples the value itself.
module smc_cfg_reg
    import smc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    output timing_t     cfg
);

    logic unused_reserved;
    assign unused_reserved = ^{wdata[31:30], wdata[27:26], wdata[23:18]};

    // Load a new configuration or return to the reset word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= unpack_cfg(CFG_RESET_WORD);
        end else if (we) begin
            cfg <= unpack_cfg(wdata);
        end
    end

endmodule

// File: rtl/smc_phase_seq.sv
// Phase sequencer: walks the bus-cycle phases, skipping any of zero length.
// Assumes cfg and is_wr are stable for the whole cycle (the top latches them).
module smc_phase_seq
    import smc_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  timing_t cfg,
    input  logic    is_wr,
    output phase_e  phase,
    output logic    strobe_end,
    output logic    done,
    output logic    idle
);

    logic [LEN_W-1:0] plen [NUM_PHASES];
    logic [LEN_W-1:0] cnt;
    phase_e           nxt;
    logic             cycle_last;

    // Length of every phase for the current configuration.
    always_comb begin
        plen[PH_IDLE]   = LEN_W'(1);
        plen[PH_ASETUP] = LEN_W'(cfg.addr_gap);
        plen[PH_CSETUP] = (cfg.early_rd && !is_wr) ? '0 : LEN_W'(cfg.cs_setup);
        plen[PH_STROBE] = cfg.wait_en ? (LEN_W'(cfg.wait_cnt) + LEN_W'(1)) : LEN_W'(1);
        plen[PH_CHOLD]  = LEN_W'(cfg.cs_hold);
        plen[PH_AHOLD]  = LEN_W'(cfg.addr_gap);
        plen[PH_FLOAT]  = is_wr ? '0 : LEN_W'(cfg.float_len);
    end

    // First phase after the current one with a nonzero length.
    always_comb begin
        logic found;
        found = 1'b0;
        nxt   = PH_IDLE;
        for (int p = 1; p < NUM_PHASES; p++) begin
            if (!found && p > int'(phase) && plen[p] != '0) begin
                nxt   = phase_e'(3'(p));
                found = 1'b1;
            end
        end
    end

    assign idle       = (phase == PH_IDLE);
    assign strobe_end = (phase == PH_STROBE) && (cnt == '0);
    assign cycle_last = !idle && (phase != PH_FLOAT) && (cnt == '0)
                        && (nxt == PH_FLOAT || nxt == PH_IDLE);

    // Advance through phases, counting each one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (idle) begin
            if (start) begin
                phase <= nxt;
                cnt   <= plen[nxt] - LEN_W'(1);
            end
        end else if (cnt != '0) begin
            cnt <= cnt - LEN_W'(1);
        end else begin
            phase <= nxt;
            cnt   <= plen[nxt] - LEN_W'(1);
        end
    end

    // Completion pulse in the clock after the last address-hold clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= cycle_last;
        end
    end

    // R9: done lasts exactly one clock.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: no float gap follows a write.
    a_r6_float_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FLOAT) |-> !is_wr);

    // R4: strobe counter never exceeds the programmed width.
    a_r4_strobe_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STROBE) |-> (cnt < plen[PH_STROBE]));

endmodule

// File: rtl/smc_lane_mux.sv
// Byte-lane steering: chip select, strobes, write data and read capture.
// Assumes DATA_W is a multiple of 8; lane 0 carries the 8-bit bus.
module smc_lane_mux
    import smc_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic              strobe_end,
    input  logic              is_wr,
    input  logic              narrow,
    input  logic              split_dev,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] din,
    output logic              cs_n,
    output logic              rd_n,
    output logic [LANES-1:0]  wr_n,
    output logic [DATA_W-1:0] dout,
    output logic              doe,
    output logic [DATA_W-1:0] rd_data
);

    logic in_cs;
    logic strobe;

    assign in_cs  = (phase == PH_CSETUP) || (phase == PH_STROBE) || (phase == PH_CHOLD);
    assign strobe = (phase == PH_STROBE);

    assign cs_n = !in_cs;
    assign rd_n = !(strobe && !is_wr);
    assign doe  = is_wr && in_cs;
    assign dout = narrow ? {LANES{wdata[7:0]}} : wdata;

    // One write strobe per byte lane, gated by bus width and device pairing.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lane_en;
        // Decide whether this lane takes part in the write.
        always_comb begin
            if (narrow) begin
                lane_en = (g == 0);
            end else if (split_dev) begin
                lane_en = be[g];
            end else begin
                lane_en = 1'b1;
            end
        end
        assign wr_n[g] = !(strobe && is_wr && lane_en);
    end

    // Capture device data on the edge where the read strobe rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (strobe_end && !is_wr) begin
            rd_data <= narrow ? {{(DATA_W-8){1'b0}}, din[7:0]} : din;
        end
    end

    // R3: no strobe while the chip select is high.
    a_r3_strobe_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !(&wr_n)) |-> !cs_n);

    // R7: the upper lane never strobes on an 8-bit bus.
    a_r7_narrow_lane: assert property (@(posedge clk) disable iff (!rst_n)
        narrow |-> wr_n[LANES-1]);

endmodule

// File: rtl/smc_cs_engine.sv
// Static memory chip-select timing engine (top).
// Accepts one request when idle, latches it with the configuration,
// and plays out address/chip-select/strobe phases on the device pins.
// Assumes a single static device on this chip select and synchronous inputs.
module smc_cs_engine
    import smc_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              req_ack,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_rd_n,
    output logic [LANES-1:0]  mem_wr_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_doe,
    input  logic [DATA_W-1:0] mem_din
);

    timing_t          cfg_live;
    timing_t          cfg_lat;
    timing_t          cfg_cur;
    logic             wr_lat;
    logic             wr_cur;
    logic [DATA_W-1:0] wdata_lat;
    logic [LANES-1:0] be_lat;
    phase_e           phase;
    logic             strobe_end;
    logic             idle;
    logic             accept;
    logic             narrow;

    smc_cfg_reg i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg_live)
    );

    assign accept  = req_valid && idle;
    assign req_ack = accept;
    assign cfg_cur = idle ? cfg_live  : cfg_lat;
    assign wr_cur  = idle ? req_write : wr_lat;
    assign narrow  = (cfg_lat.bus_sel == 2'd2);

    // Latch the request and the configuration when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_lat   <= unpack_cfg(CFG_RESET_WORD);
            wr_lat    <= 1'b0;
            wdata_lat <= '0;
            be_lat    <= '0;
            mem_addr  <= '0;
        end else if (accept) begin
            cfg_lat   <= cfg_live;
            wr_lat    <= req_write;
            wdata_lat <= req_wdata;
            be_lat    <= req_be;
            mem_addr  <= req_addr;
        end
    end

    smc_phase_seq #(.LEN_W(8)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .cfg        (cfg_cur),
        .is_wr      (wr_cur),
        .phase      (phase),
        .strobe_end (strobe_end),
        .done       (done),
        .idle       (idle)
    );

    smc_lane_mux #(.DATA_W(DATA_W)) i_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .strobe_end (strobe_end),
        .is_wr      (wr_lat),
        .narrow     (narrow),
        .split_dev  (cfg_lat.split_dev),
        .be         (be_lat),
        .wdata      (wdata_lat),
        .din        (mem_din),
        .cs_n       (mem_cs_n),
        .rd_n       (mem_rd_n),
        .wr_n       (mem_wr_n),
        .dout       (mem_dout),
        .doe        (mem_doe),
        .rd_data    (rd_data)
    );

    // R1: a request is only taken while the device pins are quiet.
    a_r1_ack_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (mem_cs_n && mem_rd_n && (&mem_wr_n)));

    // R2: the address does not move while the chip select is low.
    a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    // R9: done comes after the chip select has been released.
    a_r9_done_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> mem_cs_n);

    // R11: data is driven only during a write with chip select low.
    a_r11_doe_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_doe |-> (!mem_cs_n && wr_lat));

endmodule

// File: tb/test_smc_cs_engine.sv
module test_smc_cs_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ack;
    logic        done;
    logic [15:0] rd_data;
    logic [19:0] mem_addr;
    logic        mem_cs_n;
    logic        mem_rd_n;
    logic [1:0]  mem_wr_n;
    logic [15:0] mem_dout;
    logic        mem_doe;
    logic [15:0] mem_din = '0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    always @(posedge clk) cycles <= cycles + 1;

    smc_cs_engine i_smc_cs_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_ack(req_ack), .done(done),
        .rd_data(rd_data), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_dout(mem_dout),
        .mem_doe(mem_doe), .mem_din(mem_din)
    );

    typedef struct packed {
        logic [31:0] cfg;
        logic        wr;
        logic [19:0] addr;
        logic [15:0] wd;
        logic [1:0]  be;
        logic [15:0] din;
        logic [7:0]  total;
        logic [7:0]  cs;
        logic [7:0]  stb;
        logic [7:0]  lead;
        logic [7:0]  first;
        logic [1:0]  mask;
        logic [15:0] exp_data;
    } vec_t;

    // cfg, wr, addr, wdata, be, din | total, cs, strobe, lead, first cs, strobe mask, data
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_2000, 1'b0, 20'h00100, 16'h0000, 2'b11, 16'h1234, 8'd2,   8'd1,   8'd1,   8'd0, 8'd1, 2'b00, 16'h1234},
        '{32'h1201_2083, 1'b0, 20'h0A0B2, 16'h0000, 2'b11, 16'hBEEF, 8'd10,  8'd7,   8'd4,   8'd2, 8'd2, 2'b00, 16'hBEEF},
        '{32'h2102_2000, 1'b1, 20'h00044, 16'hCAFE, 2'b11, 16'h0000, 8'd9,   8'd4,   8'd1,   8'd1, 8'd3, 2'b11, 16'hCAFE},
        '{32'h0301_A080, 1'b0, 20'h00210, 16'h0000, 2'b11, 16'h0F0F, 8'd4,   8'd1,   8'd1,   8'd0, 8'd2, 2'b00, 16'h0F0F},
        '{32'h1300_A082, 1'b1, 20'h00318, 16'h5AA5, 2'b11, 16'h0000, 8'd8,   8'd7,   8'd3,   8'd3, 8'd1, 2'b11, 16'h5AA5},
        '{32'h1100_4000, 1'b0, 20'h00401, 16'h0000, 2'b11, 16'hA55A, 8'd4,   8'd3,   8'd1,   8'd1, 8'd1, 2'b00, 16'h005A},
        '{32'h1100_4000, 1'b1, 20'h00402, 16'h1234, 2'b11, 16'h0000, 8'd4,   8'd3,   8'd1,   8'd1, 8'd1, 2'b01, 16'h3434},
        '{32'h0000_3000, 1'b1, 20'h00500, 16'hABCD, 2'b10, 16'h0000, 8'd2,   8'd1,   8'd1,   8'd0, 8'd1, 2'b10, 16'hABCD},
        '{32'h0000_3000, 1'b1, 20'h00502, 16'h6789, 2'b01, 16'h0000, 8'd2,   8'd1,   8'd1,   8'd0, 8'd1, 2'b01, 16'h6789},
        '{32'h0000_2000, 1'b1, 20'h00600, 16'h4321, 2'b01, 16'h0000, 8'd2,   8'd1,   8'd1,   8'd0, 8'd1, 2'b11, 16'h4321},
        '{32'h0000_2007, 1'b0, 20'h00700, 16'h0000, 2'b11, 16'h7777, 8'd2,   8'd1,   8'd1,   8'd0, 8'd1, 2'b00, 16'h7777},
        '{32'h0000_20FF, 1'b0, 20'hFFFFF, 16'h0000, 2'b11, 16'h8001, 8'd129, 8'd128, 8'd128, 8'd0, 8'd1, 2'b00, 16'h8001}
    };

    // Measured results of the last transaction.
    int          m_total, m_cs, m_stb, m_first, m_fstb, m_addr_bad;
    logic [1:0]  m_mask;
    logic [15:0] m_dout, m_rd;
    logic        m_doe;

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    // Run one transaction from the current negedge; ends at the negedge of the done cycle.
    task automatic txn(input logic [31:0] cfg, input bit load_cfg, input logic wr,
                       input logic [19:0] a, input logic [15:0] wd, input logic [1:0] be,
                       input logic [15:0] din, input bit mid_cfg, input logic [31:0] mid_word);
        int n;
        if (load_cfg) begin
            cfg_we = 1'b1; cfg_wdata = cfg;
            @(negedge clk);
            cfg_we = 1'b0;
        end
        mem_din = din; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
        req_valid = 1'b1;
        #1;
        while (!req_ack) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 1'b0;
        m_total = 0; m_cs = 0; m_stb = 0; m_first = 0; m_fstb = 0; m_addr_bad = 0;
        m_mask = '0; m_dout = '0; m_doe = 1'b0; m_rd = '0;
        n = 1;
        while (n < 400) begin
            if (done) begin
                m_total = n; m_rd = rd_data;
                break;
            end
            if (mem_addr != a) m_addr_bad++;
            if (!mem_cs_n) begin
                m_cs++;
                if (m_first == 0) m_first = n;
            end
            if (!mem_rd_n || !(&mem_wr_n)) begin
                m_stb++;
                if (m_fstb == 0) m_fstb = n;
                m_mask = m_mask | ~mem_wr_n;
                m_dout = mem_dout; m_doe = mem_doe;
            end
            if (mid_cfg && n == 2) begin cfg_we = 1'b1; cfg_wdata = mid_word; end
            if (mid_cfg && n == 3) cfg_we = 1'b0;
            @(negedge clk);
            n++;
        end
    endtask

    // From a done negedge, raise a request and count cycles until it is acknowledged.
    task automatic gap(output int g);
        g = 0;
        req_write = 1'b0;
        req_valid = 1'b1;
        #1;
        while (!req_ack && g < 50) begin @(negedge clk); #1; g++; end
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
    endtask

    initial begin
        int g;
        repeat (3) @(negedge clk);
        // R11: reset state.
        chk("R11", "cs_n in reset", mem_cs_n, 1);
        chk("R11", "rd_n in reset", mem_rd_n, 1);
        chk("R11", "wr_n in reset", mem_wr_n, 3);
        chk("R11", "doe in reset", mem_doe, 0);
        chk("R11", "done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "cs_n after reset", mem_cs_n, 1);
        chk("R11", "ack with no request", req_ack, 0);

        // R10: reset configuration gives the shortest 16-bit cycle.
        txn(32'h0, 1'b0, 1'b0, 20'h00ABC, 16'h0, 2'b11, 16'hD00D, 1'b0, 32'h0);
        chk("R10", "reset cfg total", m_total, 2);
        chk("R10", "reset cfg strobe", m_stb, 1);
        chk("R9", "reset cfg read data", m_rd, 16'hD00D);

        // Table of vectors covering R2..R9.
        for (int i = 0; i < NV; i++) begin
            txn(VECS[i].cfg, 1'b1, VECS[i].wr, VECS[i].addr, VECS[i].wd, VECS[i].be,
                VECS[i].din, 1'b0, 32'h0);
            chk("R9", $sformatf("v%0d done cycle", i), m_total, VECS[i].total);
            chk("R2", $sformatf("v%0d first cs", i), m_first, VECS[i].first);
            chk("R2", $sformatf("v%0d addr moves", i), m_addr_bad, 0);
            chk("R3", $sformatf("v%0d cs low", i), m_cs, VECS[i].cs);
            chk("R4", $sformatf("v%0d strobe width", i), m_stb, VECS[i].stb);
            chk("R5", $sformatf("v%0d strobe lead", i), m_fstb - m_first, VECS[i].lead);
            chk("R8", $sformatf("v%0d write lanes", i), m_mask, VECS[i].mask);
            if (VECS[i].wr) begin
                chk("R7", $sformatf("v%0d write data", i), m_dout, VECS[i].exp_data);
                chk("R11", $sformatf("v%0d doe", i), m_doe, 1);
            end else begin
                chk("R7", $sformatf("v%0d read data", i), m_rd, VECS[i].exp_data);
                chk("R11", $sformatf("v%0d doe on read", i), m_doe, 0);
            end
        end

        // R10: a config write during a cycle does not change that cycle.
        txn(32'h1201_2083, 1'b1, 1'b0, 20'h00010, 16'h0, 2'b11, 16'h1111, 1'b1, 32'h0000_2000);
        chk("R10", "running cycle strobe", m_stb, 4);
        chk("R10", "running cycle total", m_total, 10);
        txn(32'h0, 1'b0, 1'b0, 20'h00020, 16'h0, 2'b11, 16'h2222, 1'b0, 32'h0);
        chk("R10", "next cycle uses new cfg", m_total, 2);

        // R6 and R1: float gap after a read holds off the next request.
        txn(32'h0000_2300, 1'b1, 1'b0, 20'h00030, 16'h0, 2'b11, 16'h3333, 1'b0, 32'h0);
        gap(g);
        chk("R6", "float gap after read", g, 3);
        chk("R1", "request held during gap", (g > 0) ? 1 : 0, 1);
        txn(32'h0000_2F00, 1'b1, 1'b1, 20'h00040, 16'h4444, 2'b11, 16'h0, 1'b0, 32'h0);
        gap(g);
        chk("R6", "no gap after write", g, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        wait (cycles > 150000);
        checks++;
        errors++;
        $display("FAIL watchdog R1: actual=%0d expected<150000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule